// File: doc/BRIEF.md
# Burst Read Address Sequencer

This block produces the word address for each beat of a synchronous burst read. The host supplies a burst clock, which is slower than the system clock, and an address-valid strobe. When the strobe is high at an active edge of the burst clock, the block captures a start address, a burst mode and an initial latency. The block counts the latency in active edges and then raises a ready flag. From then on, each active edge moves the address to the next word.

The active edge is selectable. It can be the rising or the falling edge of the burst clock. The burst clock is sampled into the system clock domain through a short synchronizer, and every output is registered.

The block has two kinds of burst:
- **Linear bursts** of 8, 16 or 32 words. The address wraps inside its naturally aligned group.
- **Continuous mode**. The address counts upward through the whole 21-bit space and rolls over to zero.

A new strobe at any time abandons the current burst and starts a fresh one.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_i` is high, and after its release until the first load, `addr_o` is 0 and `ready_o` is 0.
- R2: When `edge_sel_i` is 0, only rising edges of `bclk_i` are active. When it is 1, only falling edges are active. Outputs change only in response to an active edge, and they change within three system clocks of that edge. An inactive edge leaves `addr_o` and `ready_o` unchanged.
- R3: `avd_i` high at an active edge loads `start_addr_i` into `addr_o` and drives `ready_o` low.
- R4: `ready_o` rises at the L-th active edge after the load edge, with `addr_o` still equal to the start address. L is `lat_i` (2 to 7), and values 0 and 1 are treated as 2.
- R5: Once `ready_o` is high, it stays high, and each further active edge without `avd_i` advances `addr_o` by one step.
- R6: `mode_i` selects the burst: 01 is linear 8, 10 is linear 16, 11 is linear 32. In linear mode the low 3, 4 or 5 address bits count modulo the length and the bits above them stay fixed.
- R7: `mode_i` = 00 selects continuous mode, where `addr_o` increments by one and wraps from 0x1FFFFF to 0.
- R8: A strobe during a running burst restarts it: the new start address is loaded, `ready_o` drops, and the latency count begins again.
- R9: Mode and latency are captured only at the load edge. Changing `mode_i` or `lat_i` during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Host burst clock, sampled by `clk_i` |
| edge_sel_i | input | 1 | Active edge: 0 rising, 1 falling |
| avd_i | input | 1 | Address-valid strobe, active high |
| start_addr_i | input | 21 | Burst start word address |
| mode_i | input | 2 | 00 continuous, 01/10/11 linear 8/16/32 |
| lat_i | input | 3 | Initial latency in active edges (2..7) |
| addr_o | output | 21 | Current word address |
| ready_o | output | 1 | High when the word at `addr_o` is valid |

## Verification
Two situations are hardest to reach from the ports. One is the top-of-space rollover in continuous mode. The bench reaches it by loading 0x1FFFFE with minimum latency. The other is showing that the inactive edge does nothing. For that, the bench holds the burst clock high for several system clocks during falling-edge operation and checks the outputs before letting it fall.

Restart is exercised by striking the strobe while `ready_o` is high. The bench also changes mode and latency inputs mid-burst across an 8-word boundary, where a non-captured mode would show up as a wrap.

A behavioural reference model is compared against the outputs on every system clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    MODE_CONT  = 2'b00,
    MODE_LIN8  = 2'b01,
    MODE_LIN16 = 2'b10,
    MODE_LIN32 = 2'b11
  } burst_mode_e;
endpackage

// File: rtl/burst_edge_detect.sv
module burst_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic bclk_i,
  input  logic edge_sel_i,
  output logic tick_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic newer, older;

  generate
    if (SYNC_STAGES == 2) begin : g_two
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= {sync_q[0], bclk_i};
      end
    end else begin : g_many
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q <= '0;
        else       sync_q <= {sync_q[SYNC_STAGES-2:0], bclk_i};
      end
    end
  endgenerate

  assign newer  = sync_q[SYNC_STAGES-2];
  assign older  = sync_q[SYNC_STAGES-1];
  assign tick_o = edge_sel_i ? (older & ~newer) : (~older & newer);
endmodule

// File: rtl/burst_latency_ctr.sv
module burst_latency_ctr #(
  parameter int LAT_W   = 3,
  parameter int MIN_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic             ready_o
);
  localparam logic [LAT_W-1:0] LAT_FLOOR = LAT_W'(MIN_LAT);

  logic [LAT_W-1:0] wait_q;
  logic [LAT_W-1:0] lat_eff;

  assign lat_eff = (lat_i < LAT_FLOOR) ? LAT_FLOOR : lat_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wait_q  <= '0;
      ready_o <= 1'b0;
    end else if (tick_i && load_i) begin
      wait_q  <= lat_eff;
      ready_o <= 1'b0;
    end else if (tick_i) begin
      if (wait_q == LAT_W'(1)) ready_o <= 1'b1;
      if (wait_q != '0)        wait_q  <= wait_q - 1'b1;
    end
  end

  assert_ready_on_edge_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ready_o) |-> $past(tick_i) && !$past(load_i));

  assert_load_drops_ready_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_i && load_i) |=> !ready_o);

  assert_ready_sticks_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (ready_o && !(tick_i && load_i)) |=> ready_o);
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_seq_pkg::*;
#(
  parameter int AW = 21
) (
  input  logic [AW-1:0] cur_i,
  input  burst_mode_e   mode_i,
  output logic [AW-1:0] nxt_o
);
  logic [AW-1:0] wrap_mask;
  logic [AW-1:0] inc;

  assign inc = cur_i + AW'(1);

  always_comb begin
    unique case (mode_i)
      MODE_LIN8:  wrap_mask = AW'(7);
      MODE_LIN16: wrap_mask = AW'(15);
      MODE_LIN32: wrap_mask = AW'(31);
      default:    wrap_mask = '1;
    endcase
    nxt_o = (cur_i & ~wrap_mask) | (inc & wrap_mask);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW          = 21,
  parameter int LAT_W       = 3,
  parameter int MIN_LAT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             bclk_i,
  input  logic             edge_sel_i,
  input  logic             avd_i,
  input  logic [AW-1:0]    start_addr_i,
  input  logic [1:0]       mode_i,
  input  logic [LAT_W-1:0] lat_i,
  output logic [AW-1:0]    addr_o,
  output logic             ready_o
);
  logic          tick;
  logic [AW-1:0] addr_q, addr_nxt;
  burst_mode_e   mode_q;

  burst_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk_i(clk_i), .rst_i(rst_i), .bclk_i(bclk_i),
    .edge_sel_i(edge_sel_i), .tick_o(tick)
  );

  burst_latency_ctr #(.LAT_W(LAT_W), .MIN_LAT(MIN_LAT)) lat_ctr_i (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick), .load_i(avd_i),
    .lat_i(lat_i), .ready_o(ready_o)
  );

  burst_addr_step #(.AW(AW)) step_i (
    .cur_i(addr_q), .mode_i(mode_q), .nxt_o(addr_nxt)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      addr_q <= '0;
      mode_q <= MODE_CONT;
    end else if (tick && avd_i) begin
      addr_q <= start_addr_i;
      mode_q <= burst_mode_e'(mode_i);
    end else if (tick && ready_o) begin
      addr_q <= addr_nxt;
    end
  end

  assign addr_o = addr_q;

  assert_hold_without_edge_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !tick |=> $stable(addr_o) && $stable(ready_o));

  assert_load_addr_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick && avd_i) |=> addr_o == $past(start_addr_i));

  assert_linear_upper_fixed_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick && !avd_i && ready_o && mode_q != MODE_CONT)
      |=> addr_o[AW-1:5] == $past(addr_o[AW-1:5]));

  assert_cont_step_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick && !avd_i && ready_o && mode_q == MODE_CONT)
      |=> addr_o == AW'($past(addr_o) + AW'(1)));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b0;
  logic        edge_sel = 1'b0;
  logic        avd = 1'b0;
  logic [20:0] start_addr = '0;
  logic [1:0]  mode = 2'b00;
  logic [2:0]  lat = 3'd2;
  logic [20:0] addr;
  logic        ready;

  always #2 clk = ~clk;

  burst_addr_seq dut_i (
    .clk_i(clk), .rst_i(rst), .bclk_i(bclk), .edge_sel_i(edge_sel),
    .avd_i(avd), .start_addr_i(start_addr), .mode_i(mode), .lat_i(lat),
    .addr_o(addr), .ready_o(ready)
  );

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  string tag = "R1";

  int m_addr, m_wait, m_len;
  bit m_ready, b1, b2, tk;

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      m_addr = 0; m_wait = 0; m_len = 0; m_ready = 0; b1 = 0; b2 = 0;
    end else begin
      tk = edge_sel ? (b2 && !b1) : (!b2 && b1);
      if (tk) begin
        if (avd) begin
          m_addr  = int'(start_addr);
          m_len   = (mode == 2'b00) ? 0 : (4 << mode);
          m_wait  = (lat < 3'd2) ? 2 : int'(lat);
          m_ready = 0;
        end else begin
          if (m_ready) begin
            if (m_len == 0) m_addr = (m_addr + 1) % (1 << 21);
            else m_addr = (m_addr / m_len) * m_len + ((m_addr % m_len) + 1) % m_len;
          end
          if (m_wait == 1) m_ready = 1;
          if (m_wait > 0) m_wait = m_wait - 1;
        end
      end
      b2 = b1;
      b1 = bclk;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (int'(addr) != m_addr || ready != m_ready) begin
        fails++;
        $display("FAIL %s model: addr=%h ready=%0d expected addr=%h ready=%0d",
                 tag, addr, ready, m_addr, m_ready);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string r, input logic [20:0] ea, input logic er);
    checks++;
    if (addr !== ea || ready !== er) begin
      fails++;
      $display("FAIL %s: addr=%h ready=%0d expected addr=%h ready=%0d", r, addr, ready, ea, er);
    end
  endtask

  task automatic bcycle();
    bclk = 1'b1;
    repeat (2) @(negedge clk);
    bclk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic load(input logic [20:0] a, input logic [1:0] m, input logic [2:0] l);
    avd = 1'b1; start_addr = a; mode = m; lat = l;
    bcycle();
    avd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 21'h0, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", 21'h0, 1'b0);

    // linear 8, rising edge, latency 3
    tag = "R6";
    load(21'h12345, 2'b01, 3'd3);
    chk("R3", 21'h12345, 1'b0);
    bcycle(); chk("R4", 21'h12345, 1'b0);
    bcycle(); chk("R4", 21'h12345, 1'b0);
    bcycle(); chk("R4", 21'h12345, 1'b1);
    bcycle(); chk("R5", 21'h12346, 1'b1);
    bcycle(); chk("R5", 21'h12347, 1'b1);
    bcycle(); chk("R6", 21'h12340, 1'b1);

    // continuous wrap at top
    tag = "R7";
    load(21'h1FFFFE, 2'b00, 3'd2);
    bcycle(); chk("R4", 21'h1FFFFE, 1'b0);
    bcycle(); chk("R4", 21'h1FFFFE, 1'b1);
    bcycle(); chk("R7", 21'h1FFFFF, 1'b1);
    bcycle(); chk("R7", 21'h000000, 1'b1);
    bcycle(); chk("R7", 21'h000001, 1'b1);

    // falling edge, linear 32, latency 0 clamps to 2
    tag = "R2";
    edge_sel = 1'b1;
    repeat (3) @(negedge clk);
    load(21'h0003E, 2'b11, 3'd0);
    bcycle(); bcycle(); chk("R4", 21'h0003E, 1'b1);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2", 21'h0003E, 1'b1);
    bclk = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2", 21'h0003F, 1'b1);
    bcycle(); chk("R6", 21'h00020, 1'b1);

    // linear 16 on falling edge
    tag = "R6";
    load(21'h0ABCD, 2'b10, 3'd2);
    bcycle(); bcycle(); chk("R4", 21'h0ABCD, 1'b1);
    bcycle(); chk("R6", 21'h0ABCE, 1'b1);
    bcycle(); chk("R6", 21'h0ABCF, 1'b1);
    bcycle(); chk("R6", 21'h0ABC0, 1'b1);

    // restart mid-burst
    tag = "R8";
    load(21'h00100, 2'b00, 3'd4);
    chk("R8", 21'h00100, 1'b0);
    bcycle(); bcycle(); bcycle(); chk("R8", 21'h00100, 1'b0);
    bcycle(); chk("R8", 21'h00100, 1'b1);

    // inputs changed mid-burst are ignored
    tag = "R9";
    mode = 2'b01; lat = 3'd7;
    for (int i = 0; i < 8; i++) bcycle();
    chk("R9", 21'h00108, 1'b1);

    // longest latency, back to rising edge
    tag = "R4";
    edge_sel = 1'b0;
    repeat (3) @(negedge clk);
    load(21'h00055, 2'b01, 3'd7);
    for (int i = 0; i < 6; i++) bcycle();
    chk("R4", 21'h00055, 1'b0);
    bcycle(); chk("R4", 21'h00055, 1'b1);
    bcycle(); chk("R6", 21'h00056, 1'b1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule